// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits between instruction decode and two asymmetric execution pipes, called u and v. Each cycle it looks at the two oldest decoded instructions: the older slot and the younger slot. It decides whether both can start together or whether only the older one starts. The older instruction, when present, always takes the u-pipe. The younger one joins it in the v-pipe only when three things hold. Its class must be accepted by the v-pipe. The older instruction's class must leave room for a partner. There must be no register dependence between the two.

Each operation is tagged with a two-bit class code:
- 0: simple operations such as move, address computation, simple ALU, push/pop and test/compare. These may use either pipe.
- 1: shift, rotate and some floating-point operations. These are accepted only by u.
- 2: jumps, conditional jumps, calls and register exchange. These are accepted only by v.
- 3: operations that a function-unit rule forbids to pair in any position.

A register specifier is only the register index. Any partial access to a register is named with the full register's index. So a write to one part of a register conflicts with a read of any other part of it.

The decision is registered. It appears on the outputs one clock after the slots are presented, together with a consumed count that tells the feeder how many slots to retire. A younger instruction that fails to pair is not consumed. The feeder then presents it as the older slot in the following cycle.

Top module: `pair_issue_top`

## Requirements
- R1: While rstN is low, issueU and issueV are 0 and consumed is 0.
- R2: The decision for the slots sampled at a rising clock edge appears on the outputs after that edge. Changing the slot inputs between edges does not change the outputs.
- R3: When the older slot is not valid, nothing issues: issueU=0, issueV=0, consumed=0, whatever the younger slot holds.
- R4: A valid older slot always issues on the u-pipe (issueU=1), whatever its class. If the younger slot is not valid, it issues alone.
- R5: When the older class is 2 (v-only) or 3 (never pairs), the older instruction issues alone.
- R6: When the younger class is 1 (u-only) or 3 (never pairs), the younger instruction does not issue.
- R7: The pair is split when the younger slot reads a register that the older slot writes. This applies when either of the two source specifiers has its use bit set and its index equals the older destination index, with the older destination use bit set.
- R8: The pair is split when both slots write the same register index, with both destination use bits set.
- R9: A specifier whose use bit is 0 never blocks pairing, even when its index matches.
- R10: When both slots are valid, the older class is 0 or 1, the younger class is 0 or 2, and neither R7 nor R8 applies, both issue: issueU=1, issueV=1, consumed=2.
- R11: consumed always equals the number of asserted issue outputs (0, 1 or 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| oldValid | input | 1 | Older slot holds an instruction |
| oldClass | input | 2 | Older slot class code (0 any, 1 u-only, 2 v-only, 3 solo) |
| oldDstUse | input | 1 | Older slot writes a register |
| oldDst | input | REG_IDX_W | Older destination register index |
| youngValid | input | 1 | Younger slot holds an instruction |
| youngClass | input | 2 | Younger slot class code |
| youngSrcUse | input | 2 | Use bits for younger sources (bit 0: youngSrc0, bit 1: youngSrc1) |
| youngSrc0 | input | REG_IDX_W | Younger first source register index |
| youngSrc1 | input | REG_IDX_W | Younger second source register index |
| youngDstUse | input | 1 | Younger slot writes a register |
| youngDst | input | REG_IDX_W | Younger destination register index |
| issueU | output | 1 | Older instruction issued to the u-pipe |
| issueV | output | 1 | Younger instruction issued to the v-pipe |
| consumed | output | 2 | Number of slots retired this cycle |

## Verification
A class restriction and a register dependence can both apply to one pair. So can a read-after-write and a write-after-write conflict. In each case the pair must still be split exactly once, with consumed at 1 and not some other value.

The bench provokes this by sweeping every older and younger class combination against hazard patterns that include both conflicts together. It also sweeps patterns where matching indices have their use bits cleared, and it adds random slot contents.

Every cycle the outputs are compared with a behavioural model. Each outcome is credited to the first rule that decides it.

// File: rtl/pair_pkg.sv
package pair_pkg;

  typedef enum logic [1:0] {
    CLS_ANY   = 2'd0,
    CLS_UONLY = 2'd1,
    CLS_VONLY = 2'd2,
    CLS_SOLO  = 2'd3
  } opClass_t;

  typedef struct packed {
    logic u;
    logic v;
  } issueStrobe_t;

  typedef struct packed {
    logic raw;
    logic waw;
  } hazard_t;

endpackage

// File: rtl/pair_dp.sv
module pair_dp
  import pair_pkg::*;
#(
  parameter int REG_IDX_W = 3,
  parameter int NUM_SRC   = 2
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 oldDstUse,
  input  logic [REG_IDX_W-1:0]                 oldDst,
  input  logic [NUM_SRC-1:0]                   youngSrcUse,
  input  logic [NUM_SRC-1:0][REG_IDX_W-1:0]    youngSrc,
  input  logic                                 youngDstUse,
  input  logic [REG_IDX_W-1:0]                 youngDst,
  input  issueStrobe_t                         stb,
  output hazard_t                              hz,
  output logic                                 issueU,
  output logic                                 issueV,
  output logic [1:0]                           consumed
);

  logic [NUM_SRC-1:0] rawVec;

  // One comparator per younger source against the older destination
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_rawCmp
    assign rawVec[i] = youngSrcUse[i] && oldDstUse && (youngSrc[i] == oldDst);
  end

  always_comb begin
    hz.raw = |rawVec;
    hz.waw = oldDstUse && youngDstUse && (youngDst == oldDst);
  end

  // Issue stage register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      issueU   <= 1'b0;
      issueV   <= 1'b0;
      consumed <= 2'd0;
    end else begin
      issueU   <= stb.u;
      issueV   <= stb.v;
      consumed <= {stb.u & stb.v, stb.u ^ stb.v};
    end
  end

  // R7
  raw_split_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(hz.raw) |-> !issueV);

  // R8
  waw_split_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(hz.waw) |-> !issueV);

  // R4
  v_needs_u_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueV |-> issueU);

endmodule

// File: rtl/pair_ctl.sv
module pair_ctl
  import pair_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         oldValid,
  input  opClass_t     oldClass,
  input  logic         youngValid,
  input  opClass_t     youngClass,
  input  hazard_t      hz,
  output issueStrobe_t stb
);

  logic oldLeavesRoom;
  logic youngFitsV;

  always_comb begin
    oldLeavesRoom = (oldClass == CLS_ANY) || (oldClass == CLS_UONLY);
    youngFitsV    = (youngClass == CLS_ANY) || (youngClass == CLS_VONLY);
    stb.u = oldValid;
    stb.v = oldValid && youngValid && oldLeavesRoom && youngFitsV
            && !hz.raw && !hz.waw;
  end

  // R3
  no_old_no_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oldValid |-> !stb.u && !stb.v);

  // R5
  old_alone_chk: assert property (@(posedge clk) disable iff (!rstN)
    (oldClass == CLS_VONLY || oldClass == CLS_SOLO) |-> !stb.v);

  // R6
  young_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    (youngClass == CLS_UONLY || youngClass == CLS_SOLO) |-> !stb.v);

endmodule

// File: rtl/pair_issue_top.sv
module pair_issue_top
  import pair_pkg::*;
#(
  parameter int REG_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 oldValid,
  input  logic [1:0]           oldClass,
  input  logic                 oldDstUse,
  input  logic [REG_IDX_W-1:0] oldDst,
  input  logic                 youngValid,
  input  logic [1:0]           youngClass,
  input  logic [1:0]           youngSrcUse,
  input  logic [REG_IDX_W-1:0] youngSrc0,
  input  logic [REG_IDX_W-1:0] youngSrc1,
  input  logic                 youngDstUse,
  input  logic [REG_IDX_W-1:0] youngDst,
  output logic                 issueU,
  output logic                 issueV,
  output logic [1:0]           consumed
);

  localparam int NumSrc = 2;

  issueStrobe_t                         stb;
  hazard_t                              hz;
  logic [NumSrc-1:0][REG_IDX_W-1:0]     youngSrc;

  assign youngSrc = {youngSrc1, youngSrc0};

  pair_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .oldValid   (oldValid),
    .oldClass   (opClass_t'(oldClass)),
    .youngValid (youngValid),
    .youngClass (opClass_t'(youngClass)),
    .hz         (hz),
    .stb        (stb)
  );

  pair_dp #(.REG_IDX_W(REG_IDX_W), .NUM_SRC(NumSrc)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .oldDstUse   (oldDstUse),
    .oldDst      (oldDst),
    .youngSrcUse (youngSrcUse),
    .youngSrc    (youngSrc),
    .youngDstUse (youngDstUse),
    .youngDst    (youngDst),
    .stb         (stb),
    .hz          (hz),
    .issueU      (issueU),
    .issueV      (issueV),
    .consumed    (consumed)
  );

endmodule

// File: tb/tb_pair_issue_top.sv
module tb_pair_issue_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       oldValid, oldDstUse, youngValid, youngDstUse;
  logic [1:0] oldClass, youngClass, youngSrcUse;
  logic [2:0] oldDst, youngSrc0, youngSrc1, youngDst;
  logic       issueU, issueV;
  logic [1:0] consumed;

  int nChecks = 0;
  int nFail   = 0;
  logic [3:0] expQ[$];
  string      tagQ[$];

  always #2 clk = ~clk;

  pair_issue_top dut (
    .clk(clk), .rstN(rstN),
    .oldValid(oldValid), .oldClass(oldClass), .oldDstUse(oldDstUse), .oldDst(oldDst),
    .youngValid(youngValid), .youngClass(youngClass), .youngSrcUse(youngSrcUse),
    .youngSrc0(youngSrc0), .youngSrc1(youngSrc1), .youngDstUse(youngDstUse),
    .youngDst(youngDst),
    .issueU(issueU), .issueV(issueV), .consumed(consumed)
  );

  function automatic logic rawHit();
    return oldDstUse && ((youngSrcUse[0] && youngSrc0 == oldDst) ||
                         (youngSrcUse[1] && youngSrc1 == oldDst));
  endfunction

  function automatic logic wawHit();
    return oldDstUse && youngDstUse && youngDst == oldDst;
  endfunction

  // expected {issueU, issueV, consumed}
  function automatic logic [3:0] refOut();
    int u = 0;
    int v = 0;
    if (oldValid) begin
      u = 1;
      if (youngValid && oldClass inside {2'd0, 2'd1} && youngClass inside {2'd0, 2'd2}
          && !rawHit() && !wawHit())
        v = 1;
    end
    return {u[0], v[0], 2'(u + v)};
  endfunction

  function automatic string refTag();
    if (!oldValid) return "R3";
    if (oldClass >= 2) return "R5";
    if (!youngValid) return "R4";
    if (youngClass == 2'd1 || youngClass == 2'd3) return "R6";
    if (rawHit()) return "R7";
    if (wawHit()) return "R8";
    if (youngSrc0 == oldDst || youngSrc1 == oldDst || youngDst == oldDst) return "R9";
    return "R10";
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual u/v/cons=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic compareDue();
    if (expQ.size() > 0) begin
      logic [3:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, {issueU, issueV, consumed}, e);
      // R11: count matches asserted issues
      check("R11", {2'b00, consumed}, {2'b00, 2'(int'(issueU) + int'(issueV))});
    end
  endtask

  task automatic step(input logic ov, input logic [1:0] oc, input logic odu, input logic [2:0] od,
                      input logic yv, input logic [1:0] yc, input logic [1:0] ysu,
                      input logic [2:0] ys0, input logic [2:0] ys1,
                      input logic ydu, input logic [2:0] yd);
    @(negedge clk);
    compareDue();
    oldValid = ov; oldClass = oc; oldDstUse = odu; oldDst = od;
    youngValid = yv; youngClass = yc; youngSrcUse = ysu;
    youngSrc0 = ys0; youngSrc1 = ys1; youngDstUse = ydu; youngDst = yd;
    expQ.push_back(refOut());
    tagQ.push_back(refTag());
  endtask

  initial begin
    #(4 * 200000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    oldValid = 1; oldClass = 0; oldDstUse = 1; oldDst = 0;
    youngValid = 1; youngClass = 0; youngSrcUse = 0; youngSrc0 = 1;
    youngSrc1 = 2; youngDstUse = 1; youngDst = 3;
    repeat (3) @(negedge clk);
    // R1: reset holds outputs low although a pairable pair is presented
    check("R1", {issueU, issueV, consumed}, 4'b0000);
    rstN = 1'b1;
    oldValid = 0; youngValid = 0;

    // R2: an input change between edges leaves outputs untouched
    @(negedge clk);
    oldValid = 1; youngValid = 1;
    #1;
    check("R2", {issueU, issueV, consumed}, 4'b0000);
    @(negedge clk);
    check("R2", {issueU, issueV, consumed}, 4'b1110);
    oldValid = 0; youngValid = 0;

    // Directed sweep: validity x classes x hazard pattern
    for (int vo = 0; vo < 2; vo++)
      for (int vy = 0; vy < 2; vy++)
        for (int oc = 0; oc < 4; oc++)
          for (int yc = 0; yc < 4; yc++)
            for (int hzc = 0; hzc < 7; hzc++) begin
              logic [2:0] s0, s1, d;
              logic [1:0] su;
              logic du, odu;
              s0 = 1; s1 = 2; d = 6; su = 2'b11; du = 1; odu = 1;
              case (hzc)
                1: s0 = 5;                              // R7 first source
                2: s1 = 5;                              // R7 second source
                3: d = 5;                               // R8
                4: begin s0 = 5; s1 = 5; d = 5; su = 0; du = 0; end  // R9
                5: begin s0 = 5; d = 5; end             // R7 and R8 together
                6: begin s0 = 5; d = 5; odu = 0; end    // R9 older write unused
                default: ;
              endcase
              step(vo[0], oc[1:0], odu, 3'd5, vy[0], yc[1:0], su, s0, s1, du, d);
            end

    // Random phase
    for (int k = 0; k < 3000; k++)
      step(($urandom_range(0, 7) != 0), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           3'($urandom_range(0, 7)), ($urandom_range(0, 5) != 0), 2'($urandom_range(0, 3)),
           2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));

    @(negedge clk);
    compareDue();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule